// File: doc/BRIEF.md
# Two-Bank Level Interrupt Aggregator

This block merges sixty-four interrupt request lines into one interrupt output for a processor. The lines come in two groups of thirty-two, a low group and a high group. Each group keeps a pending word and a mask word. A line going high marks its pending bit, and the same line going low unmarks it. Software can also drop pending bits by writing ones to a clear offset. The processor output is raised while any bit is both pending and unmasked, in either group.

Software reaches the block through a plain register port: a byte address, a write strobe, write data, and read data that is registered one cycle. The window covers 256 bytes. Offsets that are not mapped read back as zero and take no write. The output is registered, so it follows the register state one clock later and never glitches.

Top module: `irq_bank_merge`

## Requirements
- R1: After synchronous reset, every pending word, every mask word, the processor output and the read data are all zero.
- R2: When input line i of a group goes from 0 to 1 at a clock edge, bit i of that group's pending word becomes 1 at that edge. The high pending word reads at offset 0x10 and the low pending word at offset 0x20.
- R3: When input line i goes from 1 to 0 at a clock edge, bit i of that group's pending word becomes 0 at that edge.
- R4: A write to offset 0x18 clears each high pending bit whose write-data bit is 1 and leaves every other high pending bit unchanged.
- R5: A write to offset 0x28 clears low pending bits in the same way and does not touch the high group.
- R6: The high mask word (offset 0x14) and the low mask word (offset 0x24) take all 32 bits of a write and read them back unchanged.
- R7: The processor output equals OR over bits of (low pending AND low mask) OR (high pending AND high mask), taken from the register state one clock earlier.
- R8: A pending bit cleared by software while its line stays high remains 0 until that line falls and rises again.
- R9: If a line rises at the same edge as a software clear of its bit, the bit ends up set.
- R10: Offset 0x2c and every other unmapped offset read zero, and writes to them change nothing. The clear offsets 0x18 and 0x28 read zero, and writes to the pending read offsets 0x10 and 0x20 change nothing.
- R11: The read data after a clock edge shows the addressed register as it stood just before that edge, so a read in the same cycle as a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lo_i | input | 32 | Low-group request lines, bit i is line i |
| irq_hi_i | input | 32 | High-group request lines, bit i is line i |
| reg_addr | input | 8 | Byte offset into the register window |
| reg_wr | input | 1 | Write strobe for the current offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the offset of the previous cycle |
| cpu_irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
A stale pending or mask bit shows up in two places. Reading that word back shows it one cycle after the address is presented. It also shows on the processor output one clock after the faulty register edge, as soon as the matching bit in the other word is set. The bench therefore compares both outputs on every cycle against a software model, while lines toggle and clears and mask writes arrive at random. It also drives targeted sequences for the held-high clear, the clear that collides with a rise, and the silent offsets, where a mistake would otherwise stay hidden until a line toggled.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam logic [7:0] OFS_HI_STAT = 8'h10;
  localparam logic [7:0] OFS_HI_MASK = 8'h14;
  localparam logic [7:0] OFS_HI_CLR  = 8'h18;
  localparam logic [7:0] OFS_LO_STAT = 8'h20;
  localparam logic [7:0] OFS_LO_MASK = 8'h24;
  localparam logic [7:0] OFS_LO_CLR  = 8'h28;
  localparam logic [7:0] OFS_QUIET   = 8'h2c;

  localparam int GRP_LO = 0;
  localparam int GRP_HI = 1;
  localparam int NUM_GRP = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HI_STAT,
    SEL_HI_MASK,
    SEL_HI_CLR,
    SEL_LO_STAT,
    SEL_LO_MASK,
    SEL_LO_CLR,
    SEL_QUIET
  } reg_sel_t;

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  output reg_sel_t           sel,
  output logic [NUM_GRP-1:0] mask_we,
  output logic [NUM_GRP-1:0] clr_we
);

  always_comb begin
    if      (addr == ADDR_W'(OFS_HI_STAT)) sel = SEL_HI_STAT;
    else if (addr == ADDR_W'(OFS_HI_MASK)) sel = SEL_HI_MASK;
    else if (addr == ADDR_W'(OFS_HI_CLR))  sel = SEL_HI_CLR;
    else if (addr == ADDR_W'(OFS_LO_STAT)) sel = SEL_LO_STAT;
    else if (addr == ADDR_W'(OFS_LO_MASK)) sel = SEL_LO_MASK;
    else if (addr == ADDR_W'(OFS_LO_CLR))  sel = SEL_LO_CLR;
    else if (addr == ADDR_W'(OFS_QUIET))   sel = SEL_QUIET;
    else                                   sel = SEL_NONE;
  end

  always_comb begin
    mask_we = '0;
    clr_we  = '0;
    if (wr) begin
      unique case (sel)
        SEL_HI_MASK: mask_we[GRP_HI] = 1'b1;
        SEL_LO_MASK: mask_we[GRP_LO] = 1'b1;
        SEL_HI_CLR:  clr_we[GRP_HI]  = 1'b1;
        SEL_LO_CLR:  clr_we[GRP_LO]  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irqagg_group.sv
module irqagg_group #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_i,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] stat_o,
  output logic [LINES-1:0] mask_o,
  output logic             pend_o
);

  logic [LINES-1:0] line_q;
  logic [LINES-1:0] stat_q;
  logic [LINES-1:0] mask_q;
  logic [LINES-1:0] rise_v;
  logic [LINES-1:0] fall_v;
  logic [LINES-1:0] clr_v;
  logic [LINES-1:0] stat_d;

  assign rise_v = line_i & ~line_q;
  assign fall_v = line_q & ~line_i;
  assign clr_v  = clr_we ? wdata : '0;

  // a new rising edge wins over a software clear in the same cycle
  assign stat_d = ((stat_q & ~clr_v) | rise_v) & ~fall_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      line_q <= line_i;
      stat_q <= stat_d;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & mask_q);

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (rise_v != '0) |=> ((stat_q & $past(rise_v)) == $past(rise_v))); // R2

  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fall_v != '0) |=> ((stat_q & $past(fall_v)) == '0)); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((stat_q & $past(wdata & ~rise_v)) == '0)); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((stat_q & ~$past(stat_q) & ~$past(rise_v)) == '0)); // R8

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_q == $past(wdata))); // R6

endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
  import irqagg_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_sel_t         sel,
  input  logic [LINES-1:0] stat_lo,
  input  logic [LINES-1:0] mask_lo,
  input  logic [LINES-1:0] stat_hi,
  input  logic [LINES-1:0] mask_hi,
  output logic [LINES-1:0] rdata
);

  logic [LINES-1:0] rd_d;

  always_comb begin
    unique case (sel)
      SEL_HI_STAT: rd_d = stat_hi;
      SEL_HI_MASK: rd_d = mask_hi;
      SEL_LO_STAT: rd_d = stat_lo;
      SEL_LO_MASK: rd_d = mask_lo;
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

endmodule

// File: rtl/irq_bank_merge.sv
module irq_bank_merge
  import irqagg_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  irq_lo_i,
  input  logic [LINES-1:0]  irq_hi_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  output logic              cpu_irq_o
);

  reg_sel_t           sel_w;
  logic [NUM_GRP-1:0] mask_we_w;
  logic [NUM_GRP-1:0] clr_we_w;
  logic [LINES-1:0]   lines_w [NUM_GRP];
  logic [LINES-1:0]   stat_w  [NUM_GRP];
  logic [LINES-1:0]   mask_w  [NUM_GRP];
  logic [NUM_GRP-1:0] pend_w;
  logic               irq_q;

  assign lines_w[GRP_LO] = irq_lo_i;
  assign lines_w[GRP_HI] = irq_hi_i;

  irqagg_decode #(.ADDR_W(ADDR_W)) decode_i (
    .addr    (reg_addr),
    .wr      (reg_wr),
    .sel     (sel_w),
    .mask_we (mask_we_w),
    .clr_we  (clr_we_w)
  );

  for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_grp
    irqagg_group #(.LINES(LINES)) group_i (
      .clk     (clk),
      .rst     (rst),
      .line_i  (lines_w[gi]),
      .mask_we (mask_we_w[gi]),
      .clr_we  (clr_we_w[gi]),
      .wdata   (reg_wdata),
      .stat_o  (stat_w[gi]),
      .mask_o  (mask_w[gi]),
      .pend_o  (pend_w[gi])
    );
  end

  irqagg_rdmux #(.LINES(LINES)) rdmux_i (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel_w),
    .stat_lo (stat_w[GRP_LO]),
    .mask_lo (mask_w[GRP_LO]),
    .stat_hi (stat_w[GRP_HI]),
    .mask_hi (mask_w[GRP_HI]),
    .rdata   (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_w;
  end

  assign cpu_irq_o = irq_q;

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cpu_irq_o == $past(|((stat_w[GRP_LO] & mask_w[GRP_LO]) |
                                  (stat_w[GRP_HI] & mask_w[GRP_HI]))))); // R7

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != ADDR_W'(OFS_HI_STAT) && reg_addr != ADDR_W'(OFS_HI_MASK) &&
     reg_addr != ADDR_W'(OFS_LO_STAT) && reg_addr != ADDR_W'(OFS_LO_MASK))
    |=> (reg_rdata == '0)); // R10

  AST_QUIET_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_QUIET))
    |=> ($stable(mask_w[GRP_LO]) && $stable(mask_w[GRP_HI]))); // R10

endmodule

// File: tb/irq_bank_merge_tb.sv
module irq_bank_merge_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_lo_i = '0;
  logic [31:0] irq_hi_i = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_stat [2];
  logic [31:0] m_mask [2];
  logic [31:0] m_prev [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bank_merge dut_i (
    .clk       (clk),
    .rst       (rst),
    .irq_lo_i  (irq_lo_i),
    .irq_hi_i  (irq_hi_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cpu_irq_o (cpu_irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h10:   return m_stat[1];
      8'h14:   return m_mask[1];
      8'h20:   return m_stat[0];
      8'h24:   return m_mask[0];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h10, 8'h20: return "R2";
      8'h14, 8'h24: return "R6";
      default:      return "R10";
    endcase
  endfunction

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(input string tag, input logic [7:0] a, input logic w,
                      input logic [31:0] wd, input logic [31:0] lo_in,
                      input logic [31:0] hi_in);
    logic        e_irq;
    logic [31:0] e_rd;
    logic [31:0] ins, rise, fall, clr;
    reg_addr  = a;
    reg_wr    = w;
    reg_wdata = wd;
    irq_lo_i  = lo_in;
    irq_hi_i  = hi_in;
    @(posedge clk);
    e_irq = (|(m_stat[0] & m_mask[0])) | (|(m_stat[1] & m_mask[1]));
    e_rd  = model_read(a);
    for (int b = 0; b < 2; b++) begin
      ins  = (b == 1) ? hi_in : lo_in;
      rise = ins & ~m_prev[b];
      fall = ~ins & m_prev[b];
      m_prev[b] = ins;
      clr  = (w && a == ((b == 1) ? 8'h18 : 8'h28)) ? wd : 32'h0;
      m_stat[b] = ((m_stat[b] & ~clr) | rise) & ~fall;
      if (w && a == ((b == 1) ? 8'h14 : 8'h24)) m_mask[b] = wd;
    end
    @(negedge clk);
    chk("R7", {31'd0, cpu_irq_o}, {31'd0, e_irq});
    chk(tag, reg_rdata, e_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lo_v, hi_v;
    logic [7:0]  addrs [11];
    void'($urandom(32'd4242));
    for (int b = 0; b < 2; b++) begin
      m_stat[b] = '0; m_mask[b] = '0; m_prev[b] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", {31'd0, cpu_irq_o}, 32'd0);
    chk("R1", reg_rdata, 32'd0);
    step("R1", 8'h10, 1'b0, 0, 0, 0);
    step("R1", 8'h14, 1'b0, 0, 0, 0);
    step("R1", 8'h20, 1'b0, 0, 0, 0);
    step("R1", 8'h24, 1'b0, 0, 0, 0);

    // R2: rising lines set pending bits
    step("R2", 8'h00, 1'b0, 0, 32'h0000_0001, 32'h0000_00a0);
    step("R2", 8'h10, 1'b0, 0, 32'h0000_0001, 32'h0000_00a0);
    chk("R2", reg_rdata, 32'h0000_00a0);
    step("R2", 8'h20, 1'b0, 0, 32'h0000_0001, 32'h0000_00a0);
    chk("R2", reg_rdata, 32'h0000_0001);

    // R6 / R7: masks and output
    step("R6", 8'h14, 1'b1, 32'hffff_ffff, 32'h1, 32'ha0);
    step("R6", 8'h14, 1'b0, 0, 32'h1, 32'ha0);
    chk("R6", reg_rdata, 32'hffff_ffff);
    chk("R7", {31'd0, cpu_irq_o}, 32'd1);
    step("R6", 8'h24, 1'b1, 32'h5a5a_0f0f, 32'h1, 32'ha0);
    step("R6", 8'h24, 1'b0, 0, 32'h1, 32'ha0);
    chk("R6", reg_rdata, 32'h5a5a_0f0f);

    // R11: read in the same cycle as a write returns the old value
    step("R11", 8'h14, 1'b1, 32'h0000_0080, 32'h1, 32'ha0);
    chk("R11", reg_rdata, 32'hffff_ffff);

    // R4: high clear only hits ones in the data
    step("R4", 8'h18, 1'b1, 32'h0000_0020, 32'h1, 32'ha0);
    step("R4", 8'h10, 1'b0, 0, 32'h1, 32'ha0);
    chk("R4", reg_rdata, 32'h0000_0080);

    // R8: bit 7 cleared while the line stays high stays clear
    step("R8", 8'h18, 1'b1, 32'h0000_0080, 32'h1, 32'ha0);
    step("R8", 8'h10, 1'b0, 0, 32'h1, 32'ha0);
    step("R8", 8'h10, 1'b0, 0, 32'h1, 32'ha0);
    chk("R8", reg_rdata, 32'h0);
    chk("R8", {31'd0, cpu_irq_o}, 32'd1);
    step("R8", 8'h10, 1'b0, 0, 32'h1, 32'h20);
    step("R8", 8'h10, 1'b0, 0, 32'h1, 32'ha0);
    step("R8", 8'h10, 1'b0, 0, 32'h1, 32'ha0);
    chk("R8", reg_rdata, 32'h0000_0080);

    // R3: falling line clears its bit
    step("R3", 8'h10, 1'b0, 0, 32'h1, 32'h20);
    step("R3", 8'h10, 1'b0, 0, 32'h1, 32'h20);
    chk("R3", reg_rdata, 32'h0);

    // R5: low clear leaves high group alone
    step("R5", 8'h28, 1'b1, 32'hffff_ffff, 32'h1, 32'ha0);
    step("R5", 8'h20, 1'b0, 0, 32'h1, 32'ha0);
    chk("R5", reg_rdata, 32'h0);
    step("R5", 8'h10, 1'b0, 0, 32'h1, 32'ha0);
    chk("R5", reg_rdata, 32'h0000_0080);

    // R9: rise and clear of the same bit in one cycle
    step("R9", 8'h28, 1'b1, 32'h0000_0200, 32'h201, 32'ha0);
    step("R9", 8'h20, 1'b0, 0, 32'h201, 32'ha0);
    chk("R9", reg_rdata, 32'h0000_0200);

    // R10: silent and unmapped offsets
    step("R10", 8'h2c, 1'b1, 32'hffff_ffff, 32'h201, 32'ha0);
    step("R10", 8'h2c, 1'b0, 0, 32'h201, 32'ha0);
    chk("R10", reg_rdata, 32'h0);
    step("R10", 8'h10, 1'b1, 32'h0, 32'h201, 32'ha0);
    step("R10", 8'h10, 1'b0, 0, 32'h201, 32'ha0);
    chk("R10", reg_rdata, 32'h0000_0080);
    step("R10", 8'h18, 1'b0, 0, 32'h201, 32'ha0);
    chk("R10", reg_rdata, 32'h0);

    // random traffic
    addrs = '{8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28, 8'h2c,
              8'h00, 8'h30, 8'h11, 8'hfc};
    lo_v = irq_lo_i;
    hi_v = irq_hi_i;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0]  a;
      logic        w;
      logic [31:0] wd;
      if ($urandom % 4 == 0) lo_v ^= 32'h1 << ($urandom % 32);
      if ($urandom % 4 == 0) hi_v ^= 32'h1 << ($urandom % 32);
      a  = addrs[$urandom % 11];
      w  = ($urandom % 4 == 0);
      wd = ($urandom % 2 == 0) ? $urandom : (32'h1 << ($urandom % 32));
      step(tag_of(a), a, w, wd, lo_v, hi_v);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule